// File: doc/BRIEF.md
# Vendor-Identity Decode Redirector

This block decides which of several extension decode engines owns an instruction encoding that those engines share. It holds an identity tuple, made of a vendor word and an architecture word. The active tuple picks exactly one engine as the owner of the shared encoding window. Each engine reports a raw match for the current instruction. The block returns a one-hot grant and raises an illegal-instruction flag when no enabled engine claims a window instruction.

A build-time switch selects between two variants. In the first, the tuple is fixed, which declares a core that implements one standard variant and carries no custom extensions. In the second, the tuple can be written, and writes follow WARL rules. A writable core can therefore give a shared encoding a different meaning in each loop iteration by issuing one identity write between the iterations.

The block only redirects decoding. It has no path that clears or disables state inside an engine. After each accepted switch it raises a stall request for a fixed number of cycles.

Top module: `vid_decode_redirector`

## Requirements
- R1: After reset, the active tuple is table entry 0, reading vendor VENDOR_BASE and arch ARCH_BASE. Engine 0 is enabled and stall_req is low.
- R2: When WARL_WRITABLE=0, the read outputs report entry 0 at all times, and every write is ignored. Stall_req stays low and engine 0 keeps the window.
- R3: Table entry k, for k from 0 to NUM_TUPLES-1, is the tuple with vendor VENDOR_BASE+k and arch ARCH_BASE+(k<<8). In a writable build, a write that carries entry k on both halves makes that entry active from the next cycle, and the read outputs return it.
- R4: A write whose vendor and arch words do not form one table entry leaves the active tuple unchanged and does not raise stall_req. This includes halves taken from two different entries.
- R5: While entry k is active, only engine k mod NUM_ENGINES can be granted. For a valid instruction whose bits [6:0] equal WINDOW_OPCODE, eng_grant is eng_match ANDed with that engine's one-hot enable, in the same cycle. At most one grant bit is ever high.
- R6: When insn_valid is low, or when bits [6:0] differ from WINDOW_OPCODE, eng_grant is all zero and insn_illegal is low, whatever eng_match holds.
- R7: insn_illegal is high exactly when a valid window instruction gets no grant.
- R8: stall_req is high for exactly STALL_CYCLES cycles, beginning in the cycle after an accepted write. A new accepted write restarts the count.
- R9: An instruction presented in the same cycle as an accepted write is still granted under the old tuple. The next instruction is granted under the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_wr_en | input | 1 | Identity write strobe |
| id_wr_vendor | input | 32 | Vendor word to write |
| id_wr_arch | input | 32 | Architecture word to write |
| id_rd_vendor | output | 32 | Active vendor word |
| id_rd_arch | output | 32 | Active architecture word |
| insn_valid | input | 1 | Instruction present |
| insn | input | 32 | Instruction word; bits [6:0] select the shared window |
| eng_match | input | NUM_ENGINES | Raw per-engine match for the shared encoding |
| eng_grant | output | NUM_ENGINES | One-hot ownership grant |
| insn_illegal | output | 1 | Window instruction with no owner |
| stall_req | output | 1 | Stall request after an identity switch |

## Verification
The bench places a window instruction in the same cycle as an identity write. A design that applied the new enable combinationally would grant the new engine one cycle early. The bench writes tuples whose halves come from two different entries. A comparator that checked only one half would wrongly switch engines and raise a stall. A second write lands while a stall is still counting, which exposes a counter that ignores the restart or one that stops one cycle early or late. A read-only instance receives the same writes and shows whether any write leaks through in that variant.

// File: rtl/vid_redir_pkg.sv
package vid_redir_pkg;
    localparam int ID_W  = 32;
    localparam int OPC_W = 7;

    typedef logic [ID_W-1:0] id_word_t;

    typedef struct packed {
        id_word_t vendor;
        id_word_t arch;
    } id_tuple_t;

    // Entry k of the supported-identity table
    function automatic id_tuple_t tuple_at(id_word_t vbase, id_word_t abase, int k);
        id_tuple_t t;
        t.vendor = vbase + id_word_t'(k);
        t.arch   = abase + (id_word_t'(k) << 8);
        return t;
    endfunction
endpackage

// File: rtl/vid_tuple_table.sv
module vid_tuple_table
    import vid_redir_pkg::*;
#(
    parameter int       NUM_TUPLES  = 4,
    parameter int       IDX_W       = 2,
    parameter id_word_t VENDOR_BASE = 32'h0000_0A00,
    parameter id_word_t ARCH_BASE   = 32'h8000_0001
) (
    input  id_tuple_t        probe,
    input  logic [IDX_W-1:0] sel_idx,
    output logic             probe_hit,
    output logic [IDX_W-1:0] probe_idx,
    output id_tuple_t        sel_tuple
);
    id_tuple_t              entry [NUM_TUPLES];
    logic [NUM_TUPLES-1:0]  hit_vec;

    for (genvar k = 0; k < NUM_TUPLES; k++) begin : g_entry
        assign entry[k]   = tuple_at(VENDOR_BASE, ARCH_BASE, k);
        assign hit_vec[k] = (probe == entry[k]);
    end

    // Entries are distinct, so at most one hit bit is set
    always_comb begin
        probe_hit = |hit_vec;
        probe_idx = '0;
        for (int k = 0; k < NUM_TUPLES; k++) begin
            if (hit_vec[k]) probe_idx = probe_idx | IDX_W'(k);
        end
    end

    always_comb begin
        sel_tuple = entry[0];
        for (int k = 0; k < NUM_TUPLES; k++) begin
            if (sel_idx == IDX_W'(k)) sel_tuple = entry[k];
        end
    end
endmodule

// File: rtl/vid_ident_state.sv
module vid_ident_state #(
    parameter int NUM_TUPLES    = 4,
    parameter int NUM_ENGINES   = 4,
    parameter int STALL_CYCLES  = 3,
    parameter bit WARL_WRITABLE = 1'b1,
    parameter int IDX_W         = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic                   wr_hit,
    input  logic [IDX_W-1:0]       wr_idx,
    output logic [IDX_W-1:0]       active_idx,
    output logic [NUM_ENGINES-1:0] eng_enable,
    output logic                   stall_req
);
    localparam int CNT_W = (STALL_CYCLES > 0) ? $clog2(STALL_CYCLES + 1) : 1;

    typedef struct packed {
        logic [IDX_W-1:0]       idx;
        logic [NUM_ENGINES-1:0] en;
        logic [CNT_W-1:0]       cnt;
    } state_t;

    function automatic logic [NUM_ENGINES-1:0] engine_onehot(logic [IDX_W-1:0] idx);
        logic [NUM_ENGINES-1:0] oh;
        for (int e = 0; e < NUM_ENGINES; e++) begin
            oh[e] = ((int'(idx) % NUM_ENGINES) == e);
        end
        return oh;
    endfunction

    state_t st_d, st_q;
    logic   accept;

    if (WARL_WRITABLE) begin : g_warl
        assign accept = wr_en & wr_hit;
    end else begin : g_fixed
        assign accept = wr_en & wr_hit & 1'b0;
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.idx = wr_idx;
            st_d.en  = engine_onehot(wr_idx);
            st_d.cnt = CNT_W'(STALL_CYCLES);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idx <= '0;
            st_q.en  <= engine_onehot('0);
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_idx = st_q.idx;
    assign eng_enable = st_q.en;
    assign stall_req  = (st_q.cnt != '0);
endmodule

// File: rtl/vid_grant_gate.sv
module vid_grant_gate #(
    parameter int              NUM_ENGINES   = 4,
    parameter int              OPC_W         = 7,
    parameter logic [OPC_W-1:0] WINDOW_OPCODE = 7'h0B
) (
    input  logic                   insn_valid,
    input  logic [OPC_W-1:0]       insn_opc,
    input  logic [NUM_ENGINES-1:0] eng_match,
    input  logic [NUM_ENGINES-1:0] eng_enable,
    output logic [NUM_ENGINES-1:0] eng_grant,
    output logic                   insn_illegal
);
    logic in_window;
    assign in_window = insn_valid && (insn_opc == WINDOW_OPCODE);

    // One AND per engine: the redirection costs a single gate level
    for (genvar e = 0; e < NUM_ENGINES; e++) begin : g_and
        assign eng_grant[e] = in_window & eng_match[e] & eng_enable[e];
    end

    assign insn_illegal = in_window & ~(|eng_grant);
endmodule

// File: rtl/vid_decode_redirector.sv
module vid_decode_redirector
    import vid_redir_pkg::*;
#(
    parameter int               NUM_ENGINES   = 4,
    parameter int               NUM_TUPLES    = 4,
    parameter int               STALL_CYCLES  = 3,
    parameter bit               WARL_WRITABLE = 1'b1,
    parameter logic [31:0]      VENDOR_BASE   = 32'h0000_0A00,
    parameter logic [31:0]      ARCH_BASE     = 32'h8000_0001,
    parameter logic [6:0]       WINDOW_OPCODE = 7'h0B
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   id_wr_en,
    input  logic [31:0]            id_wr_vendor,
    input  logic [31:0]            id_wr_arch,
    output logic [31:0]            id_rd_vendor,
    output logic [31:0]            id_rd_arch,
    input  logic                   insn_valid,
    input  logic [31:0]            insn,
    input  logic [NUM_ENGINES-1:0] eng_match,
    output logic [NUM_ENGINES-1:0] eng_grant,
    output logic                   insn_illegal,
    output logic                   stall_req
);
    localparam int IDX_W = (NUM_TUPLES > 1) ? $clog2(NUM_TUPLES) : 1;

    id_tuple_t              wr_tuple, rd_tuple;
    logic                   wr_hit;
    logic [IDX_W-1:0]       wr_idx, active_idx;
    logic [NUM_ENGINES-1:0] eng_enable;
    logic                   unused_insn_hi;

    assign wr_tuple.vendor = id_wr_vendor;
    assign wr_tuple.arch   = id_wr_arch;
    assign unused_insn_hi  = ^insn[ID_W-1:OPC_W];

    vid_tuple_table #(
        .NUM_TUPLES (NUM_TUPLES),
        .IDX_W      (IDX_W),
        .VENDOR_BASE(VENDOR_BASE),
        .ARCH_BASE  (ARCH_BASE)
    ) u_table (
        .probe    (wr_tuple),
        .sel_idx  (active_idx),
        .probe_hit(wr_hit),
        .probe_idx(wr_idx),
        .sel_tuple(rd_tuple)
    );

    vid_ident_state #(
        .NUM_TUPLES   (NUM_TUPLES),
        .NUM_ENGINES  (NUM_ENGINES),
        .STALL_CYCLES (STALL_CYCLES),
        .WARL_WRITABLE(WARL_WRITABLE),
        .IDX_W        (IDX_W)
    ) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (id_wr_en),
        .wr_hit    (wr_hit),
        .wr_idx    (wr_idx),
        .active_idx(active_idx),
        .eng_enable(eng_enable),
        .stall_req (stall_req)
    );

    vid_grant_gate #(
        .NUM_ENGINES  (NUM_ENGINES),
        .OPC_W        (OPC_W),
        .WINDOW_OPCODE(WINDOW_OPCODE)
    ) u_gate (
        .insn_valid  (insn_valid),
        .insn_opc    (insn[OPC_W-1:0]),
        .eng_match   (eng_match),
        .eng_enable  (eng_enable),
        .eng_grant   (eng_grant),
        .insn_illegal(insn_illegal)
    );

    assign id_rd_vendor = rd_tuple.vendor;
    assign id_rd_arch   = rd_tuple.arch;
endmodule

// File: rtl/vid_redirect_checker.sv
module vid_redirect_checker #(
    parameter int NUM_ENGINES   = 4,
    parameter int STALL_CYCLES  = 3,
    parameter bit WARL_WRITABLE = 1'b1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   id_wr_en,
    input logic [31:0]            id_rd_vendor,
    input logic [31:0]            id_rd_arch,
    input logic                   insn_valid,
    input logic [NUM_ENGINES-1:0] eng_match,
    input logic [NUM_ENGINES-1:0] eng_grant,
    input logic                   insn_illegal,
    input logic                   stall_req
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_grant)); // R5

    AST_GRANT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_grant & ~eng_match) == '0); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |-> (eng_grant == '0) && !insn_illegal); // R6

    AST_ILLEGAL_UNOWNED: assert property (@(posedge clk) disable iff (!rst_n)
        insn_illegal |-> (eng_grant == '0)); // R7

    AST_NO_WRITE_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
        !id_wr_en |=> $stable(id_rd_vendor) && $stable(id_rd_arch)); // R4

    AST_FIXED_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (WARL_WRITABLE == 1'b0) |=> $stable(id_rd_vendor) && $stable(id_rd_arch) && !stall_req); // R2

    AST_SWITCH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (STALL_CYCLES > 0) && !$stable(id_rd_vendor) |-> stall_req); // R8
endmodule

bind vid_decode_redirector vid_redirect_checker #(
    .NUM_ENGINES  (NUM_ENGINES),
    .STALL_CYCLES (STALL_CYCLES),
    .WARL_WRITABLE(WARL_WRITABLE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .id_wr_en    (id_wr_en),
    .id_rd_vendor(id_rd_vendor),
    .id_rd_arch  (id_rd_arch),
    .insn_valid  (insn_valid),
    .eng_match   (eng_match),
    .eng_grant   (eng_grant),
    .insn_illegal(insn_illegal),
    .stall_req   (stall_req)
);

// File: tb/sim_vid_decode_redirector.sv
module sim_vid_decode_redirector;
    localparam int          NE  = 4;
    localparam int          NT  = 4;
    localparam int          STL = 3;
    localparam logic [31:0] VB  = 32'h0000_0A00;
    localparam logic [31:0] AB  = 32'h8000_0001;
    localparam logic [6:0]  WIN = 7'h0B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_v = '0, wr_a = '0;
    logic          iv = 1'b0;
    logic [31:0]   ins = '0;
    logic [NE-1:0] mt = '0;

    logic [31:0]   rv0, ra0, rv1, ra1;
    logic [NE-1:0] g0, g1;
    logic          il0, il1, st0, st1;

    integer checks = 0, fails = 0;
    integer m_idx = 0, m_stall = 0;
    string  phase = "R1";

    always #2 clk = ~clk;

    vid_decode_redirector #(.NUM_ENGINES(NE), .NUM_TUPLES(NT), .STALL_CYCLES(STL),
        .WARL_WRITABLE(1'b1), .VENDOR_BASE(VB), .ARCH_BASE(AB), .WINDOW_OPCODE(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .id_wr_en(wr_en), .id_wr_vendor(wr_v), .id_wr_arch(wr_a),
        .id_rd_vendor(rv0), .id_rd_arch(ra0), .insn_valid(iv), .insn(ins), .eng_match(mt),
        .eng_grant(g0), .insn_illegal(il0), .stall_req(st0));

    vid_decode_redirector #(.NUM_ENGINES(NE), .NUM_TUPLES(NT), .STALL_CYCLES(STL),
        .WARL_WRITABLE(1'b0), .VENDOR_BASE(VB), .ARCH_BASE(AB), .WINDOW_OPCODE(WIN)) u1 (
        .clk(clk), .rst_n(rst_n), .id_wr_en(wr_en), .id_wr_vendor(wr_v), .id_wr_arch(wr_a),
        .id_rd_vendor(rv1), .id_rd_arch(ra1), .insn_valid(iv), .insn(ins), .eng_match(mt),
        .eng_grant(g1), .insn_illegal(il1), .stall_req(st1));

    function automatic logic [31:0] vend(int k); return VB + k; endfunction
    function automatic logic [31:0] arch(int k); return AB + (k << 8); endfunction
    function automatic logic [31:0] winsn(int hi); return {hi[24:0], WIN}; endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) %s: actual %h expected %h", req, phase, what, act, exp);
        end
    endtask

    task automatic compare();
        logic          inwin;
        logic [NE-1:0] eg0, eg1;
        inwin = iv && (ins[6:0] == WIN);
        eg0 = inwin ? (mt & NE'(1 << (m_idx % NE))) : '0;
        eg1 = inwin ? (mt & NE'(1)) : '0;
        chk("R5", "grant", 32'(g0), 32'(eg0));
        chk("R7", "illegal", 32'(il0), 32'(inwin && eg0 == '0));
        chk("R8", "stall", 32'(st0), 32'(m_stall != 0));
        chk("R3", "rd_vendor", rv0, vend(m_idx));
        chk("R3", "rd_arch", ra0, arch(m_idx));
        chk("R2", "ro grant", 32'(g1), 32'(eg1));
        chk("R2", "ro illegal", 32'(il1), 32'(inwin && eg1 == '0));
        chk("R2", "ro stall", 32'(st1), 32'd0);
        chk("R2", "ro rd_vendor", rv1, vend(0));
        chk("R2", "ro rd_arch", ra1, arch(0));
    endtask

    task automatic step(input logic we, input logic [31:0] v, input logic [31:0] a,
                        input logic val, input logic [31:0] i, input logic [NE-1:0] m);
        int hit;
        wr_en = we; wr_v = v; wr_a = a; iv = val; ins = i; mt = m;
        #1;
        compare();
        @(posedge clk);
        hit = -1;
        for (int k = 0; k < NT; k++) if (v == vend(k) && a == arch(k)) hit = k;
        if (we && hit >= 0) begin
            m_idx = hit; m_stall = STL;
        end else if (m_stall > 0) begin
            m_stall--;
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int j = 0; j < n; j++) step(1'b0, '0, '0, 1'b0, '0, '0);
    endtask

    task automatic wr(int k);
        step(1'b1, vend(k), arch(k), 1'b0, '0, '0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R1";                                // reset tuple, engine 0 owns window
        idle(2);

        phase = "R5";
        step(1'b0, '0, '0, 1'b1, winsn(5), 4'b0001);
        step(1'b0, '0, '0, 1'b1, winsn(6), 4'b1111);
        phase = "R7";
        step(1'b0, '0, '0, 1'b1, winsn(7), 4'b1110);
        step(1'b0, '0, '0, 1'b1, winsn(8), 4'b0000);

        phase = "R6";                                // outside window or not valid
        step(1'b0, '0, '0, 1'b1, 32'h0000_0033, 4'b1111);
        step(1'b0, '0, '0, 1'b0, winsn(9), 4'b1111);

        phase = "R9";                                // write with instruction in same cycle
        step(1'b1, vend(2), arch(2), 1'b1, winsn(1), 4'b1111);
        phase = "R3";
        step(1'b0, '0, '0, 1'b1, winsn(2), 4'b1111);
        step(1'b0, '0, '0, 1'b1, winsn(3), 4'b0100);
        step(1'b0, '0, '0, 1'b1, winsn(3), 4'b0001);

        phase = "R8";                                // stall length and restart
        idle(3);
        wr(1);
        idle(1);
        wr(3);
        idle(5);

        phase = "R4";                                // unsupported tuples
        step(1'b1, vend(1), arch(2), 1'b0, '0, '0);
        idle(1);
        step(1'b1, vend(NT), arch(NT), 1'b0, '0, '0);
        step(1'b1, '0, '0, 1'b1, winsn(4), 4'b1000);
        step(1'b1, vend(3), arch(3) ^ 32'h1, 1'b1, winsn(4), 4'b1000);
        idle(2);

        phase = "R9";                                // per-iteration meaning change
        for (int it = 0; it < 8; it++) begin
            wr(it % 2);
            step(1'b0, '0, '0, 1'b1, winsn(it), 4'b0011);
            idle(2);
        end

        phase = "R2";                                // mixed sweep, read-only copy compared too
        for (int j = 0; j < 400; j++) begin
            logic we;
            int   k;
            we = ($urandom_range(0, 3) == 0);
            k  = $urandom_range(0, NT);
            step(we, vend(k), ($urandom_range(0, 4) == 0) ? arch(k) + 1 : arch(k),
                 $urandom_range(0, 1) == 1,
                 ($urandom_range(0, 3) == 0) ? 32'h0000_0013 : winsn(j),
                 NE'($urandom_range(0, 15)));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule